// File: doc/BRIEF.md
# Self-Clearing Peripheral Reset Pulse Sequencer

This block drives the resets of a small group of peripherals from one 32-bit control register. Software writes a 1 to a channel's request bit. The hardware then runs a fixed sequence for that channel:

1. Stop the peripheral clock.
2. Raise the reset.
3. Hold for a programmable window.
4. Drop the reset.
5. Hold for the same window again.
6. Restart the clock.

Software never writes the request bit back to 0. The hardware clears it when the sequence ends, and in the same cycle it raises a sticky done flag. Software clears a done flag by writing a 1 to it.

The window is an 8-bit count of 0.25 µs ticks. One shared prescaler produces those ticks by dividing the block clock by `CYC_PER_TICK` cycles. Each channel copies the window value when its sequence starts. Each channel also has its own counter, so channels run independently and may overlap.

Top module: `periph_reset_seq`

## Requirements
- R1: Any register write with bit i set (i < NUM_CH, request bits at 0..NUM_CH-1) starts channel i's sequence, with no qualifier. Request bit i reads 1 from the cycle after that write until the sequence ends. A write with no request bit set starts nothing.
- R2: In the cycle after the launching write, `ch_clk_en[i]` is 0 and `ch_rst[i]` is still 0. The cycle after that, `ch_rst[i]` is 1.
- R3: The reset stays high for D cycles. With window W and T = CYC_PER_TICK, D = 1 when W = 0. Otherwise (W-1)*T+2 ≤ D ≤ W*T+1.
- R4: After the reset falls, `ch_clk_en[i]` stays 0 for a further D cycles, bounded as in R3. `ch_clk_en[i]` then returns to 1. In that same cycle, request bit i reads 0 and done flag i reads 1.
- R5: Done flag i sits at bit DONE_LSB+i (bits 28..31 by default). Writing 1 there clears it. Writing 0 leaves it unchanged. Other channels' flags are not disturbed.
- R6: The reset outputs are active high. After `rst_n` is released, every `ch_rst` is 0, every `ch_clk_en` is 1 and `reg_rdata` is 0.
- R7: Writing 1 to the request bit of a busy channel has no effect, and the running sequence keeps its timing.
- R8: Channels run independently. Several launched by one write run their sequences at the same time, and each sets its own done flag.
- R9: All bits of `reg_rdata` other than the request and done bits read 0, including after writes of 1 to them.
- R10: The window is sampled when a sequence launches. Changing `win_ticks` while a channel is busy does not change that channel's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data: request bits low, done-clear bits at DONE_LSB |
| reg_rdata | output | 32 | Live request (busy) bits and done flags |
| win_ticks | input | WIN_W | Window length in 0.25 µs ticks |
| ch_rst | output | NUM_CH | Active-high reset per channel |
| ch_clk_en | output | NUM_CH | Clock enable per channel, 0 while sequencing |

## Verification
The hardest case to reach from the ports is a repeat request that lands in the middle of a running reset. A restart would show up only as a slightly different pulse length, so the stimulus writes the request again at a chosen cycle inside the reset-high phase. It then checks that the measured pulse still falls within the tick-phase bounds of the original window. A similar mid-sequence change of `win_ticks` exercises the window sampling. The bounds themselves come from the unknown phase of the shared prescaler. For that reason the bench checks every duration against a closed interval derived from the window, not against a single cycle count.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_GATE   = 2'd1,
    SEQ_HOLD   = 2'd2,
    SEQ_SETTLE = 2'd3
  } seq_state_e;

  // Bits of the control register that carry live state.
  function automatic logic [REG_W-1:0] live_mask(input int n_ch, input int done_lsb);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n_ch; i++) begin
      m[i]            = 1'b1;
      m[done_lsb + i] = 1'b1;
    end
    return m;
  endfunction

  // Next value of a sticky done flag: a completion wins over a clear.
  function automatic logic done_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int CYC_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] div_q;
  logic          wrap;

  assign wrap = (div_q == LAST);
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (wrap) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  // R3
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST);

endmodule

// File: rtl/seq_channel.sv
module seq_channel
  import rst_seq_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             launch,
  input  logic [WIN_W-1:0] win_ticks,
  output logic             busy,
  output logic             finish,
  output logic             ch_rst,
  output logic             ch_clk_en
);

  seq_state_e       state_q, state_d;
  logic [WIN_W-1:0] cnt_q, win_q;
  logic             window_met;
  logic             counting;

  assign counting   = (state_q == SEQ_HOLD) || (state_q == SEQ_SETTLE);
  assign window_met = (cnt_q == win_q);
  assign finish     = (state_q == SEQ_SETTLE) && window_met;
  assign busy       = (state_q != SEQ_IDLE);
  assign ch_rst     = (state_q == SEQ_HOLD);
  assign ch_clk_en  = (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (launch)     state_d = SEQ_GATE;
      SEQ_GATE:                   state_d = SEQ_HOLD;
      SEQ_HOLD:   if (window_met) state_d = SEQ_SETTLE;
      SEQ_SETTLE: if (window_met) state_d = SEQ_IDLE;
      default:                    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE && launch) win_q <= win_ticks;
      if (!counting || window_met) cnt_q <= '0;
      else if (tick)               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  gate_before_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_rst) |-> $past(!ch_clk_en));

  // R4
  release_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_clk_en) |-> $past(!ch_rst));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_GATE) |-> ($past(state_q) == SEQ_IDLE));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= win_q));

  // R10
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(win_q));

endmodule

// File: rtl/periph_reset_seq.sv
module periph_reset_seq
  import rst_seq_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int WIN_W        = 8,
  parameter int DONE_LSB     = 28,
  parameter int CYC_PER_TICK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [WIN_W-1:0]  win_ticks,
  output logic [NUM_CH-1:0] ch_rst,
  output logic [NUM_CH-1:0] ch_clk_en
);

  localparam logic [REG_W-1:0] LIVE = live_mask(NUM_CH, DONE_LSB);

  logic              tick;
  logic [NUM_CH-1:0] launch, clear, fin, busy, done_q;

  tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign launch[g] = reg_wr & reg_wdata[g];
    assign clear[g]  = reg_wr & reg_wdata[DONE_LSB + g];

    seq_channel #(.WIN_W(WIN_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .launch(launch[g]), .win_ticks(win_ticks),
      .busy(busy[g]), .finish(fin[g]),
      .ch_rst(ch_rst[g]), .ch_clk_en(ch_clk_en[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q[g] <= 1'b0;
      else        done_q[g] <= done_next(done_q[g], fin[g], clear[g]);
    end

    // R4
    finish_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin[g] |=> (done_q[g] && !busy[g] && ch_clk_en[g]));

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear[g] && !fin[g]) |=> !done_q[g]);

    // R5
    done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear[g] && !fin[g]) |=> (done_q[g] == $past(done_q[g])));
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      reg_rdata[i]            = busy[i];
      reg_rdata[DONE_LSB + i] = done_q[i];
    end
  end

  // R9
  rdata_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~LIVE) == '0);

endmodule

// File: tb/test_periph_reset_seq.sv
`timescale 1ns/1ps
module test_periph_reset_seq;
  localparam int T  = 4;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  win_ticks = '0;
  logic [NC-1:0] ch_rst, ch_clk_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  periph_reset_seq #(.NUM_CH(NC), .WIN_W(8), .DONE_LSB(28), .CYC_PER_TICK(T)) i_periph_reset_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .win_ticks(win_ticks),
    .ch_rst(ch_rst), .ch_clk_en(ch_clk_en)
  );

  // {channel[9:8], window[7:0]}
  localparam logic [9:0] VEC [7] = '{
    {2'd0, 8'd0}, {2'd1, 8'd1}, {2'd2, 8'd2}, {2'd3, 8'd5},
    {2'd0, 8'd8}, {2'd2, 8'd17}, {2'd1, 8'd255}
  };

  function automatic int lo_d(int w); return (w == 0) ? 1 : (w - 1) * T + 2; endfunction
  function automatic int hi_d(int w); return (w == 0) ? 1 : w * T + 1;       endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic range_chk(input string req, input int d, input int w);
    checks++;
    if (d < lo_d(w) || d > hi_d(w)) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, d, lo_d(w), hi_d(w));
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // Called at the negedge right after the launching edge.
  task automatic observe(input int ch, input int w, input int poke_at);
    int hold = 0;
    int rel  = 0;
    chk(ch_clk_en[ch] == 1'b0 && ch_rst[ch] == 1'b0, "R2 clock off, reset low",
        {ch_clk_en[ch], ch_rst[ch]}, 0);
    chk(reg_rdata[ch] == 1'b1, "R1 request bit reads busy", reg_rdata[ch], 1);
    @(negedge clk);
    while (ch_rst[ch]) begin
      hold++;
      if (hold == poke_at) begin reg_wr = 1'b1; reg_wdata = 32'(1) << ch; end
      else begin reg_wr = 1'b0; reg_wdata = '0; end
      @(negedge clk);
    end
    reg_wr = 1'b0; reg_wdata = '0;
    range_chk("R3 reset-high duration", hold, w);
    chk(ch_clk_en[ch] == 1'b0, "R4 clock still off after release", ch_clk_en[ch], 0);
    while (!ch_clk_en[ch]) begin
      rel++;
      @(negedge clk);
    end
    range_chk("R4 post-release window", rel, w);
    chk(reg_rdata[ch] == 1'b0 && reg_rdata[28 + ch] == 1'b1, "R4 request cleared, done set",
        {reg_rdata[28 + ch], reg_rdata[ch]}, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6
    chk(ch_rst == '0, "R6 resets low", ch_rst, 0);
    chk(ch_clk_en == '1, "R6 clocks on", ch_clk_en, 15);
    chk(reg_rdata == '0, "R6 read zero", reg_rdata, 0);

    // R9 and R1: write to unused bits starts nothing
    wr(32'h0FFF_FFF0);
    chk(ch_clk_en == '1 && ch_rst == '0, "R1 no launch without request bit", ch_clk_en, 15);
    chk(reg_rdata == '0, "R9 unused bits read 0", reg_rdata, 0);

    // Table walk: R1 R2 R3 R4
    for (int k = 0; k < 7; k++) begin
      wr(32'hF000_0000);
      win_ticks = VEC[k][7:0];
      wr(32'(1) << VEC[k][9:8]);
      observe(int'(VEC[k][9:8]), int'(VEC[k][7:0]), -1);
    end

    // R5: write 0 keeps, write 1 clears only its own flag
    wr(32'hF000_0000);
    win_ticks = 8'd1;
    wr(32'h1); observe(0, 1, -1);
    wr(32'h4); observe(2, 1, -1);
    wr(32'h0);
    chk(reg_rdata == 32'h5000_0000, "R5 write 0 keeps done", reg_rdata, 32'h5000_0000);
    wr(32'h1000_0000);
    chk(reg_rdata == 32'h4000_0000, "R5 write 1 clears own flag", reg_rdata, 32'h4000_0000);
    wr(32'h4000_0000);

    // R7: request rewritten mid-reset is ignored
    win_ticks = 8'd10;
    wr(32'h2);
    observe(1, 10, 6);
    wr(32'h2000_0000);

    // R10: window changed while busy
    win_ticks = 8'd2;
    wr(32'h8);
    win_ticks = 8'd200;
    observe(3, 2, -1);
    wr(32'h8000_0000);

    // R8: two channels at once
    win_ticks = 8'd3;
    wr(32'h5);
    chk(ch_clk_en == 4'b1010, "R8 both channels gated", ch_clk_en, 4'b1010);
    @(negedge clk);
    chk(ch_rst == 4'b0101, "R8 both resets high", ch_rst, 4'b0101);
    for (int n = 0; n < 200 && reg_rdata[3:0] != 4'b0; n++) @(negedge clk);
    chk(reg_rdata == 32'h5000_0000, "R8 both done, others idle", reg_rdata, 32'h5000_0000);
    chk(ch_clk_en == '1 && ch_rst == '0, "R8 all released", ch_clk_en, 15);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule